// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns a 64-bit effective address into a real address by walking a radix tree that lives in memory. A request carries the address, whether the access is a load or a store, whether it comes from problem (user) state, and whether translation is switched on. With translation off, the address is returned unchanged. With translation on, the walker fetches the process-table entry selected by the current process ID. That entry gives the tree size, the root table base and the root index width. The walker then checks that the address falls inside the tree. After that it reads one 8-byte entry per level until it reaches a leaf, and merges the leaf's real page number with the untranslated low bits of the address.

The walker has one outstanding read at a time on a simple request/acknowledge memory port, and accepts one translation at a time. Every walk ends with a single-cycle `done` that carries either a real address or a 2-bit fault code: 0 segment, 1 invalid entry, 2 permission, 3 malformed tree. The walker keeps no cache and delivers no interrupts.

Top module: `rtw_walker`

## Requirements
- R1: With `req_xlate` low, the request completes with `done` in the first cycle after it is accepted. `rsp_pa` equals `req_va`, `rsp_fault` is low, and no memory read is issued.
- R2: The first read of a translated walk is at `prtbl_base | (pid << 4)`. The pid is `cur_pid`, or zero when address bit 63 is set. Every memory read address has its low three bits zero.
- R3: The process-table entry holds the tree size in bits 61:56, the root base in bits 55:8 and the root index width in bits 4:0. The walk ends with fault code 0 if address bits 63 and 62 differ, or if any address bit from 31+treesize up to 61 is set.
- R4: An index width is the entry's bits 4:0 with a zero above them. The shift budget starts at treesize+19. A width below 5, above 16 or above the remaining budget ends the walk with code 3. Otherwise the width is subtracted from the budget.
- R5: The next entry address keeps base bits 55:19 and replaces the low `width` bits of base bits 18:3 with the same bits of (address bits 61:12 shifted right by the budget). Bits 2:0 are zero and bits 63:56 are zero.
- R6: A fetched entry with bit 63 clear ends the walk with code 1, and `rsp_store` repeats the request's mode.
- R7: A leaf (bit 62 set) needs bit 6 for a load and bit 5 for a store. Bit 7 marks a supervisor-only page, which faults for a problem-state request. A failed check ends the walk with code 2.
- R8: A good leaf yields a real address with bits 63:56 zero. Bits 55:12 come from the leaf's bits 55:12 except the lowest `budget` of them, which come from the address. Bits 11:0 come from the address.
- R9: A walk reads at most 4 tree entries. A fourth entry that is a valid non-leaf ends the walk with code 3.
- R10: `busy` is high from acceptance until the cycle after `done`. Requests are taken only while `busy` is low, and `done` lasts exactly one cycle.
- R11: `mem_req` stays high with an unchanged `mem_addr` until the cycle in which `mem_ack` is seen, and `mem_rdata` is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request, taken when `busy` is low |
| req_va | input | 64 | Effective address |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_user | input | 1 | Request from problem state |
| req_xlate | input | 1 | Data relocation enabled |
| prtbl_base | input | 64 | Process table base address |
| cur_pid | input | 32 | Current process ID |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 64 | Memory read byte address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| done | output | 1 | Walk result valid, one cycle |
| rsp_pa | output | 64 | Real address when no fault |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_code | output | 2 | Fault code |
| rsp_store | output | 1 | Mode of the finished request |

## Verification
With the memory answering LAT cycles after a read is raised, `done` is due 1 cycle after acceptance without translation. With translation it is due 3+LAT cycles after acceptance when the walk stops at the segment or root-width check, plus LAT+2 cycles for every tree entry read. The bench derives that cycle from its own reference walk and compares `done` on every clock of the walk, so an early, late or repeated `done` is caught. Results and the full trace of read addresses are compared in the `done` cycle.

// File: rtl/rtw_pkg.sv
// Shared constants and types of the radix walker.
// Assumes 64-bit addresses, 4 KiB base pages and 8-byte tree entries.
package rtw_pkg;
    localparam int unsigned VA_W    = 64;
    localparam int unsigned PG_SH   = 12;
    localparam int unsigned SEG_LO  = 31;
    localparam int unsigned TOP_IX  = 61;
    localparam int unsigned IDX_MIN = 5;
    localparam int unsigned IDX_MAX = 16;
    localparam int unsigned SH_W    = 7;
    localparam int unsigned RPN_W   = 44;
    localparam int unsigned BASE_W  = 48;

    typedef enum logic [1:0] {
        FLT_SEG     = 2'd0,
        FLT_INVALID = 2'd1,
        FLT_PERM    = 2'd2,
        FLT_BADTREE = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PRTE_FETCH, ST_SEG_CHECK, ST_PTE_FETCH, ST_DECODE, ST_DONE
    } walk_st_e;
endpackage

// File: rtl/rtw_seg.sv
// Range check of an address against the tree size, and the starting
// shift budget. Assumes va_hi holds address bits 63:31.
module rtw_seg
    import rtw_pkg::*;
(
    input  logic [VA_W-1:SEG_LO] va_hi,
    input  logic [5:0]           tsize,
    output logic                 seg_err,
    output logic [SH_W-1:0]      init_shift
);
    // Flag a sign mismatch or any set bit above the tree's reach.
    always_comb begin
        seg_err = (va_hi[VA_W-1] != va_hi[VA_W-2]);
        for (int b = SEG_LO; b <= TOP_IX; b++) begin
            if (va_hi[b] && (b >= int'(SEG_LO) + int'(tsize)))
                seg_err = 1'b1;
        end
    end

    // Budget is the number of page-number bits the tree covers.
    assign init_shift = SH_W'(tsize) + SH_W'(SEG_LO - PG_SH);
endmodule

// File: rtl/rtw_nextaddr.sv
// Forms the byte address of the next tree entry from the table base,
// the index width and the shifted page number. Assumes width <= 16.
module rtw_nextaddr
    import rtw_pkg::*;
(
    input  logic [TOP_IX:PG_SH] vpn,
    input  logic [SH_W-1:0]     shift,
    input  logic [5:0]          isize,
    input  logic [BASE_W-1:0]   base,
    output logic [VA_W-1:0]     nxt_addr
);
    localparam int unsigned VPN_W = TOP_IX - PG_SH + 1;

    logic [VPN_W-1:0] shifted;
    logic [15:0]      idx;
    logic [15:0]      mask;
    logic [15:0]      base16;

    // Select the index bits and splice them into the base.
    always_comb begin
        shifted  = vpn >> shift;
        idx      = shifted[15:0];
        mask     = 16'((17'd1 << isize) - 17'd1);
        base16   = {base[10:0], 5'b00000};
        nxt_addr = {8'h00, base[BASE_W-1:11], (base16 & ~mask) | (idx & mask), 3'b000};
    end
endmodule

// File: rtl/rtw_leaf.sv
// Permission check of a leaf and merge of its page number with the
// address offset. Assumes shift is the budget left when the leaf is read.
module rtw_leaf
    import rtw_pkg::*;
(
    input  logic [55:0]      va_lo,
    input  logic [RPN_W-1:0] rpn,
    input  logic [2:0]       perm,
    input  logic [SH_W-1:0]  shift,
    input  logic             is_store,
    input  logic             is_user,
    output logic             perm_err,
    output logic [VA_W-1:0]  phys
);
    logic [RPN_W-1:0] fmask;

    // Access rights: perm[2] supervisor-only, perm[1] read, perm[0] write.
    assign perm_err = (is_store ? !perm[0] : !perm[1]) || (perm[2] && is_user);

    // Low budget bits of the page number pass through from the address.
    always_comb begin
        fmask = (shift >= SH_W'(RPN_W)) ? '1 : RPN_W'((45'd1 << shift) - 45'd1);
        phys  = {8'h00, (rpn & ~fmask) | (va_lo[55:PG_SH] & fmask), va_lo[PG_SH-1:0]};
    end
endmodule

// File: rtl/rtw_walker.sv
// Radix tree walker: one translation at a time, one memory read at a
// time. Assumes memory answers each read with a one-cycle mem_ack while
// mem_req is high, and that prtbl_base is aligned so the pid offset ORs in.
module rtw_walker
    import rtw_pkg::*;
#(
    parameter int unsigned MAX_LEVELS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [63:0]     req_va,
    input  logic            req_store,
    input  logic            req_user,
    input  logic            req_xlate,
    input  logic [63:0]     prtbl_base,
    input  logic [31:0]     cur_pid,
    output logic            busy,
    output logic            mem_req,
    output logic [63:0]     mem_addr,
    input  logic            mem_ack,
    input  logic [63:0]     mem_rdata,
    output logic            done,
    output logic [63:0]     rsp_pa,
    output logic            rsp_fault,
    output logic [1:0]      rsp_code,
    output logic            rsp_store
);
    localparam int unsigned LVL_W = $clog2(MAX_LEVELS + 1);

    walk_st_e          st;
    logic [VA_W-1:0]   va_q, prte_addr_q, pa_q, ent_q;
    logic              store_q, user_q, fault_q;
    fault_e            code_q;
    logic [BASE_W-1:0] base_q;
    logic [5:0]        isize_q;
    logic [SH_W-1:0]   shift_q;
    logic [LVL_W-1:0]  lvl_q;

    logic              seg_err, perm_err;
    logic [SH_W-1:0]   init_shift;
    logic [VA_W-1:0]   nxt_addr, leaf_pa;
    logic [5:0]        ent_size;
    logic              size_bad_root, size_bad_next;

    rtw_seg u_seg (
        .va_hi      (va_q[VA_W-1:SEG_LO]),
        .tsize      (ent_q[61:56]),
        .seg_err    (seg_err),
        .init_shift (init_shift)
    );

    rtw_nextaddr u_nxt (
        .vpn      (va_q[TOP_IX:PG_SH]),
        .shift    (shift_q),
        .isize    (isize_q),
        .base     (base_q),
        .nxt_addr (nxt_addr)
    );

    rtw_leaf u_leaf (
        .va_lo    (va_q[55:0]),
        .rpn      (ent_q[55:PG_SH]),
        .perm     (ent_q[7:5]),
        .shift    (shift_q),
        .is_store (store_q),
        .is_user  (user_q),
        .perm_err (perm_err),
        .phys     (leaf_pa)
    );

    // Index width of the held entry and its legality against each budget.
    always_comb begin
        ent_size      = {1'b0, ent_q[4:0]};
        size_bad_root = (ent_size < 6'(IDX_MIN)) || (ent_size > 6'(IDX_MAX)) ||
                        (SH_W'(ent_size) > init_shift);
        size_bad_next = (ent_size < 6'(IDX_MIN)) || (ent_size > 6'(IDX_MAX)) ||
                        (SH_W'(ent_size) > shift_q);
    end

    // Walk sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            va_q        <= '0;
            prte_addr_q <= '0;
            pa_q        <= '0;
            ent_q       <= '0;
            store_q     <= 1'b0;
            user_q      <= 1'b0;
            fault_q     <= 1'b0;
            code_q      <= FLT_SEG;
            base_q      <= '0;
            isize_q     <= '0;
            shift_q     <= '0;
            lvl_q       <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (req_valid) begin
                    va_q        <= req_va;
                    store_q     <= req_store;
                    user_q      <= req_user;
                    fault_q     <= 1'b0;
                    prte_addr_q <= prtbl_base |
                                   {28'h0, (req_va[63] ? 32'h0 : cur_pid), 4'h0};
                    if (req_xlate) begin
                        st <= ST_PRTE_FETCH;
                    end else begin
                        pa_q <= req_va;
                        st   <= ST_DONE;
                    end
                end
                ST_PRTE_FETCH: if (mem_ack) begin
                    ent_q <= mem_rdata;
                    st    <= ST_SEG_CHECK;
                end
                ST_SEG_CHECK: begin
                    if (seg_err) begin
                        fault_q <= 1'b1;
                        code_q  <= FLT_SEG;
                        st      <= ST_DONE;
                    end else if (size_bad_root) begin
                        fault_q <= 1'b1;
                        code_q  <= FLT_BADTREE;
                        st      <= ST_DONE;
                    end else begin
                        shift_q <= init_shift - SH_W'(ent_size);
                        isize_q <= ent_size;
                        base_q  <= ent_q[55:8];
                        lvl_q   <= '0;
                        st      <= ST_PTE_FETCH;
                    end
                end
                ST_PTE_FETCH: if (mem_ack) begin
                    ent_q <= mem_rdata;
                    lvl_q <= lvl_q + 1'b1;
                    st    <= ST_DECODE;
                end
                ST_DECODE: begin
                    if (!ent_q[63]) begin
                        fault_q <= 1'b1;
                        code_q  <= FLT_INVALID;
                        st      <= ST_DONE;
                    end else if (ent_q[62]) begin
                        fault_q <= perm_err;
                        code_q  <= FLT_PERM;
                        pa_q    <= leaf_pa;
                        st      <= ST_DONE;
                    end else if ((lvl_q >= LVL_W'(MAX_LEVELS)) || size_bad_next) begin
                        fault_q <= 1'b1;
                        code_q  <= FLT_BADTREE;
                        st      <= ST_DONE;
                    end else begin
                        shift_q <= shift_q - SH_W'(ent_size);
                        isize_q <= ent_size;
                        base_q  <= ent_q[55:8];
                        st      <= ST_PTE_FETCH;
                    end
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Port drive from held state.
    always_comb begin
        busy      = (st != ST_IDLE);
        done      = (st == ST_DONE);
        mem_req   = (st == ST_PRTE_FETCH) || (st == ST_PTE_FETCH);
        mem_addr  = (st == ST_PRTE_FETCH) ? prte_addr_q : nxt_addr;
        rsp_pa    = pa_q;
        rsp_fault = fault_q;
        rsp_code  = code_q;
        rsp_store = store_q;
    end
endmodule

// File: rtl/rtw_walker_chk.sv
// Protocol and sequencing properties of the walker, observed at its ports.
// Assumes the same MAX_LEVELS as the walker it is bound to.
module rtw_walker_chk #(
    parameter int unsigned MAX_LEVELS = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        mem_req,
    input logic [63:0] mem_addr,
    input logic        mem_ack,
    input logic        done,
    input logic        rsp_fault
);
    int unsigned rd_cnt;

    // Count reads completed inside the current walk.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) rd_cnt <= 0;
        else if (mem_req && mem_ack) rd_cnt <= rd_cnt + 1;
    end

    a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[2:0] == 3'b000);

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req && !done);

    a_r9_read_cap: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> rd_cnt <= MAX_LEVELS + 1);

    a_r1_short_walk_clean: assert property (@(posedge clk) disable iff (!rst_n)
        done && $rose(busy) |-> !rsp_fault);
endmodule

bind rtw_walker rtw_walker_chk #(.MAX_LEVELS(MAX_LEVELS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .done      (done),
    .rsp_fault (rsp_fault)
);

// File: tb/sim_rtw_walker.sv
`timescale 1ns/1ps
// Bench: behavioural reference walk over a sparse memory, cycle-exact
// comparison of done, results and the read-address trace.
module sim_rtw_walker;
    localparam int LAT = 2;
    localparam logic [63:0] PB = 64'h1_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_store = 1'b0, req_user = 1'b0, req_xlate = 1'b0;
    logic [63:0] req_va = '0;
    logic [31:0] cur_pid = '0;
    logic        busy, mem_req, mem_ack, done, rsp_fault, rsp_store;
    logic [63:0] mem_addr, mem_rdata, rsp_pa;
    logic [1:0]  rsp_code;

    int checks = 0;
    int errors = 0;
    logic [63:0] mem [logic [63:0]];
    logic [63:0] got_q[$];
    logic [63:0] exp_q[$];
    int lat_cnt;

    always #10 clk = ~clk;

    rtw_walker u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_store(req_store), .req_user(req_user), .req_xlate(req_xlate),
        .prtbl_base(PB), .cur_pid(cur_pid), .busy(busy), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
        .rsp_code(rsp_code), .rsp_store(rsp_store)
    );

    function automatic logic [63:0] rd(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    // Memory: acknowledge LAT cycles after a read is raised, log its address.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0; mem_rdata <= '0; lat_cnt = 0;
        end else if (mem_req && !mem_ack) begin
            if (lat_cnt == LAT - 1) begin
                mem_ack <= 1'b1; mem_rdata <= rd(mem_addr);
                got_q.push_back(mem_addr); lat_cnt = 0;
            end else lat_cnt++;
        end else begin
            mem_ack <= 1'b0; lat_cnt = 0;
        end
    end

    function automatic logic [63:0] msk(input int n);
        return (64'd1 << n) - 64'd1;
    endfunction

    function automatic logic [63:0] slot(input logic [63:0] base, va, input int sh, sz);
        logic [63:0] ix = ({14'b0, va[61:12]} >> sh) & msk(sz);
        return (base & ~(msk(sz) << 3)) | (ix << 3);
    endfunction

    function automatic logic [63:0] dir_e(input logic [63:0] base, input int sz);
        return 64'h8000_0000_0000_0000 | (base & 64'h00FF_FFFF_FFFF_FF00) | 64'(sz);
    endfunction

    function automatic logic [63:0] leaf_e(input logic [63:0] pa, input bit r, w, p);
        return 64'hC000_0000_0000_0000 | (pa & 64'h00FF_FFFF_FFFF_F000) |
               (64'(p) << 7) | (64'(r) << 6) | (64'(w) << 5);
    endfunction

    function automatic logic [63:0] prt_e(input int tsz, input logic [63:0] base, input int sz);
        return (64'(tsz) << 56) | (base & 64'h00FF_FFFF_FFFF_FF00) | 64'(sz);
    endfunction

    // Reference walk straight from the requirements.
    task automatic ref_walk(input logic [63:0] va, input bit st, us, xl, input logic [31:0] pid,
                            output logic [63:0] pa, output bit flt, output logic [1:0] code,
                            output int ptes);
        logic [63:0] e, a, base, lowm;
        int sh, sz;
        exp_q.delete(); pa = '0; flt = 0; code = 2'd0; ptes = 0;
        if (!xl) begin pa = va; return; end
        a = PB + 64'(va[63] ? 32'd0 : pid) * 16;
        e = rd(a); exp_q.push_back(a);
        if (va[63] != va[62]) begin flt = 1; code = 2'd0; return; end
        for (int b = 31 + int'(e[61:56]); b <= 61; b++)
            if (va[b]) begin flt = 1; code = 2'd0; return; end
        sh = int'(e[61:56]) + 19; sz = int'(e[4:0]);
        if (sz < 5 || sz > 16 || sz > sh) begin flt = 1; code = 2'd3; return; end
        sh -= sz; base = {8'h0, e[55:8], 8'h0};
        for (int lv = 1; lv <= 8; lv++) begin
            a = slot(base, va, sh, sz);
            e = rd(a); exp_q.push_back(a); ptes = lv;
            if (!e[63]) begin flt = 1; code = 2'd1; return; end
            if (e[62]) begin
                if ((st ? !e[5] : !e[6]) || (e[7] && us)) begin flt = 1; code = 2'd2; return; end
                lowm = (sh >= 44) ? 64'h00FF_FFFF_FFFF_FFFF : msk(sh + 12);
                pa = ({8'h0, e[55:12], 12'h0} & ~lowm) | (va & lowm);
                return;
            end
            if (lv == 4) begin flt = 1; code = 2'd3; return; end
            sz = int'(e[4:0]);
            if (sz < 5 || sz > 16 || sz > sh) begin flt = 1; code = 2'd3; return; end
            sh -= sz; base = {8'h0, e[55:8], 8'h0};
        end
    endtask

    task automatic chk(input string r, input logic [63:0] got, exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", r, got, exp);
        end
    endtask

    task automatic run(input string tag, input logic [63:0] va, input bit st, us, xl,
                       input logic [31:0] pid, input bit poke);
        logic [63:0] epa; bit ef; logic [1:0] ec; int ptes, nexp, cyc, bad_cyc;
        ref_walk(va, st, us, xl, pid, epa, ef, ec, ptes);
        nexp = xl ? (3 + LAT + ptes * (LAT + 2)) : 1;
        got_q.delete();
        @(negedge clk);
        req_valid = 1; req_va = va; req_store = st; req_user = us; req_xlate = xl; cur_pid = pid;
        @(negedge clk);
        req_valid = 0; cyc = 1; bad_cyc = 0;
        forever begin
            if (poke && cyc == 2) begin req_valid = 1; req_va = 64'h1_0000_0000; end
            if (poke && cyc == 3) req_valid = 0;
            if (done !== (cyc == nexp) && bad_cyc == 0) bad_cyc = cyc;
            if (done || cyc > 200) break;
            @(negedge clk); cyc++;
        end
        chk({tag, " R10 done cycle"}, 64'(cyc), 64'(nexp));
        chk({tag, " R10 done cycle clean"}, 64'(bad_cyc), 64'd0);
        chk({tag, " fault flag"}, 64'(rsp_fault), 64'(ef));
        if (ef) chk({tag, " fault code"}, 64'(rsp_code), 64'(ec));
        else    chk({tag, " real address"}, rsp_pa, epa);
        if (ef && ec == 2'd1) chk({tag, " R6 mode echo"}, 64'(rsp_store), 64'(st));
        chk({tag, " R5 R11 read count"}, 64'(got_q.size()), 64'(exp_q.size()));
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            chk({tag, " R2 R5 read address"}, got_q[i], exp_q[i]);
        @(negedge clk);
        chk({tag, " R10 idle after done"}, 64'(busy), 64'd0);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] va_a, va_b, va_d, va_e, va_f;
        va_a = 64'h0000_0012_3456_7ABC;
        va_b = 64'h0000_0055_0012_3456;
        va_d = 64'h0000_0033_0000_0000;
        va_e = 64'h0000_0022_0000_0000;
        va_f = 64'hC000_0000_0040_5678;
        mem[PB + 64'h00] = prt_e(9, 64'h6_0000, 13);
        mem[PB + 64'h30] = prt_e(9, 64'h2_0000, 10);
        mem[PB + 64'h50] = prt_e(9, 64'h2_0000, 4);
        mem[PB + 64'h60] = prt_e(31, 64'h7_0000, 5);
        mem[slot(64'h2_0000, va_a, 18, 10)] = dir_e(64'h3_0000, 9);
        mem[slot(64'h3_0000, va_a, 9, 9)]   = dir_e(64'h4_0000, 9);
        mem[slot(64'h4_0000, va_a, 0, 9)]   = leaf_e(64'hAB_CDEF_0000, 1, 0, 0);
        mem[slot(64'h2_0000, va_b, 18, 10)] = dir_e(64'h5_0000, 9);
        mem[slot(64'h5_0000, va_b, 9, 9)]   = leaf_e(64'h77_0000_0000, 1, 1, 1);
        mem[slot(64'h2_0000, va_d, 18, 10)] = dir_e(64'hB_0000, 17);
        mem[slot(64'h2_0000, va_e, 18, 10)] = dir_e(64'h9_0000, 12);
        mem[slot(64'h9_0000, va_e, 6, 12)]  = dir_e(64'hA_0000, 9);
        mem[slot(64'h6_0000, va_f, 15, 13)] = leaf_e(64'h88_0000_0000, 1, 1, 0);
        mem[64'h7_0000] = dir_e(64'h7_0000, 5);

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        @(negedge clk);
        chk("R10 reset busy", 64'(busy), 64'd0);
        chk("R10 reset done", 64'(done), 64'd0);
        chk("R11 reset mem_req", 64'(mem_req), 64'd0);

        run("R1 untranslated", 64'hDEAD_BEEF_0000_1234, 0, 0, 0, 32'd3, 0);
        run("R8 three-level load", va_a, 0, 0, 1, 32'd3, 0);
        run("R7 store to read-only", va_a, 1, 0, 1, 32'd3, 0);
        run("R8 large page", va_b, 0, 0, 1, 32'd3, 0);
        run("R7 user on supervisor page", va_b, 0, 1, 1, 32'd3, 0);
        run("R6 missing entry", 64'h0000_0001_0000_0000, 1, 0, 1, 32'd3, 0);
        run("R3 bit above tree", 64'h0000_0100_0000_0000, 0, 0, 1, 32'd3, 0);
        run("R3 sign mismatch", 64'h8000_0000_0000_1000, 0, 0, 1, 32'd3, 0);
        run("R2 pid forced zero", va_f, 0, 1, 1, 32'd3, 0);
        run("R4 root width too small", 64'h1000, 0, 0, 1, 32'd5, 0);
        run("R4 width above 16", va_d, 0, 0, 1, 32'd3, 0);
        run("R4 width above budget", va_e, 0, 0, 1, 32'd3, 0);
        run("R9 level cap", 64'h1000, 0, 0, 1, 32'd6, 0);
        run("R10 request while busy", va_a, 0, 0, 1, 32'd3, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule